// File: doc/BRIEF.md
# I2C Slave-Transmitter Status Controller

This block is the transmit half of an I2C slave. It watches SCL and SDA, recognises its own 7-bit address when the read bit is set, and shifts bytes out to the master. Every bus event is reported to a host processor through a one-byte status code and an interrupt flag. After each event the block waits. The host reads the status, loads the next byte if one is needed, and then clears the flag. The control bits written together with that clear choose what happens next.

When a transfer ends, either because the master refuses a byte or because the last byte was accepted, the block falls back to listening. The acknowledge-enable bit decides whether its address is answered again. A start request bit can queue a START condition, and that START is driven once a STOP shows the bus is free. A prescaled counter watches for SCL being held low for too long. It raises a timeout status, and clearing that status puts the block back to idle.

Top module: `i2c_slv_tx`

## Requirements
- R1: After reset, irq_o is 0, SDA is released, the status register (address 1) reads 0xF8 and the control register (address 0) reads 0x00. Control bit layout: bit0 AA (acknowledge enable), bit1 SI (interrupt flag), bit2 STO (write-only, reads 0), bit3 STA (reads 1 while a START request is pending). The data register is at address 2.
- R2: With AA=0, a read addressed to OWN_ADDR gets no acknowledge: SDA stays released in the ack slot and irq_o stays 0.
- R3: With AA=1, a read addressed to any other address gets no acknowledge and raises no interrupt.
- R4: With AA=1, a read addressed to OWN_ADDR is acknowledged (SDA low in the ack slot). irq_o then rises and the status reads 0xA8.
- R5: Writing the control register with bit1=0 while SI is set drops irq_o, and the status then reads 0xF8.
- R6: A clear from status 0xA8 or 0xB8 loads the data register. The byte goes out MSB first, one bit per SCL period.
- R7: A byte loaded with AA=1 and acknowledged by the master gives status 0xB8.
- R8: A byte loaded with AA=0 and acknowledged by the master gives status 0xC8.
- R9: A byte not acknowledged by the master gives status 0xC0.
- R10: After a clear from 0xC0 or 0xC8, the block no longer addresses itself. The next own-address read is acknowledged only if AA was 1 in that clear.
- R11: A clear from 0xC0 or 0xC8 with STA=1 makes a START request pending, and control bit3 reads 1. SDA is not touched while the bus is busy. After a STOP, SDA is pulled low with SCL high for START_HOLD cycles, then released, and bit3 reads 0.
- R12: SCL held low for PRESC_DIV*TO_TICKS cycles sets status 0xD8 and irq_o, once per low period. Any high SCL level restarts the count.
- R13: Clearing SI from 0xD8 returns the block to idle. Status reads 0xF8 and own-address reads are acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt flag (SI) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
A wrong engine state shows on the bus within a single SCL period. It appears as an acknowledge where none belongs, a missing one, or a wrong data bit at the next rising SCL. A wrong ending of a byte gives the wrong status code, readable a few cycles after the ninth falling SCL edge. A lost or premature START request shows as SDA driven low before the STOP, or no pull-down within a few cycles after it. A timeout fault shows as irq_o rising too early, too late, twice in one low period, or after a high pulse that should have restarted the count.

// File: rtl/i2c_st_pkg.sv
package i2c_st_pkg;
  typedef enum logic [7:0] {
    ST_ADDR_ACK = 8'hA8,
    ST_TX_ACK   = 8'hB8,
    ST_TX_NACK  = 8'hC0,
    ST_LAST_ACK = 8'hC8,
    ST_SCL_TMO  = 8'hD8,
    ST_NONE     = 8'hF8
  } st_code_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  localparam int CB_AA  = 0;
  localparam int CB_SI  = 1;
  localparam int CB_STO = 2;
  localparam int CB_STA = 3;
endpackage

// File: rtl/i2c_st_sync.sv
module i2c_st_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] ff;
    logic              prev;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff   <= '1;
        prev <= 1'b1;
      end else begin
        ff   <= {ff[STAGES-2:0], in_i[g]};
        prev <= ff[STAGES-1];
      end
    end
    assign lvl_o[g]  = ff[STAGES-1];
    assign rise_o[g] = ff[STAGES-1] & ~prev;
    assign fall_o[g] = ~ff[STAGES-1] & prev;
  end
endmodule

// File: rtl/i2c_st_timeout.sv
module i2c_st_timeout #(
  parameter int PRESC_DIV = 50000,
  parameter int TO_TICKS  = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic to_o
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int TW = $clog2(TO_TICKS + 1);

  logic [PW-1:0] pcnt;
  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = (pcnt == PW'(PRESC_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt <= '0;
      tcnt <= '0;
      to_o <= 1'b0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      to_o <= 1'b0;
      if (scl_i) begin
        tcnt <= '0;
      end else if (tick && tcnt != TW'(TO_TICKS)) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == TW'(TO_TICKS - 1)) to_o <= 1'b1;
      end
    end
  end

  p_tmo_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_o |-> !$past(scl_i));
endmodule

// File: rtl/i2c_st_startgen.sv
module i2c_st_startgen #(
  parameter int START_HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic cancel_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic pend_o,
  output logic drive_o
);
  localparam int HW = (START_HOLD > 1) ? $clog2(START_HOLD) : 1;

  logic          busy;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy <= 1'b0;
    else if (start_i) busy <= 1'b1;
    else if (stop_i) busy <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      drive_o <= 1'b0;
      hcnt    <= '0;
    end else if (cancel_i) begin
      pend_o  <= 1'b0;
      drive_o <= 1'b0;
      hcnt    <= '0;
    end else if (drive_o) begin
      hcnt <= hcnt + 1'b1;
      if (hcnt == HW'(START_HOLD - 1)) drive_o <= 1'b0;
    end else if (req_i) begin
      pend_o <= 1'b1;
    end else if (pend_o && !busy && scl_i && sda_i) begin
      drive_o <= 1'b1;
      pend_o  <= 1'b0;
      hcnt    <= '0;
    end
  end

  p_start_after_pend_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_o) |-> $past(pend_o));
endmodule

// File: rtl/i2c_st_engine.sv
module i2c_st_engine
  import i2c_st_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       aa_i,
  input  logic [7:0] data_i,
  input  logic       load_i,
  input  logic       release_i,
  output logic       ev_o,
  output logic [7:0] code_o,
  output logic       sda_low_o
);
  typedef enum logic [2:0] {E_IDLE, E_ADDR, E_AACK, E_WAIT, E_TX, E_MACK} eng_st_e;

  eng_st_e    st;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       last;
  logic       nack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= E_IDLE;
      sh        <= '0;
      cnt       <= '0;
      last      <= 1'b0;
      nack      <= 1'b0;
      ev_o      <= 1'b0;
      code_o    <= ST_NONE;
      sda_low_o <= 1'b0;
    end else begin
      ev_o <= 1'b0;
      if (release_i || stop_i) begin
        st        <= E_IDLE;
        sda_low_o <= 1'b0;
      end else if (start_i) begin
        st        <= E_ADDR;
        cnt       <= '0;
        sda_low_o <= 1'b0;
      end else begin
        unique case (st)
          E_IDLE: ;
          E_ADDR: begin
            if (scl_rise_i) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              if (sh[7:1] == OWN_ADDR && sh[0] && aa_i) begin
                st        <= E_AACK;
                sda_low_o <= 1'b1;
              end else begin
                st <= E_IDLE;
              end
            end
          end
          E_AACK: if (scl_fall_i) begin
            sda_low_o <= 1'b0;
            ev_o      <= 1'b1;
            code_o    <= ST_ADDR_ACK;
            st        <= E_WAIT;
          end
          E_WAIT: if (load_i) begin
            sh        <= data_i;
            last      <= ~aa_i;
            cnt       <= '0;
            sda_low_o <= ~data_i[7];
            st        <= E_TX;
          end
          E_TX: if (scl_fall_i) begin
            if (cnt == 4'd7) begin
              sda_low_o <= 1'b0;
              st        <= E_MACK;
            end else begin
              sh        <= {sh[6:0], 1'b0};
              sda_low_o <= ~sh[6];
              cnt       <= cnt + 1'b1;
            end
          end
          E_MACK: begin
            if (scl_rise_i) nack <= sda_i;
            else if (scl_fall_i) begin
              ev_o   <= 1'b1;
              code_o <= nack ? ST_TX_NACK : (last ? ST_LAST_ACK : ST_TX_ACK);
              st     <= E_WAIT;
            end
          end
          default: st <= E_IDLE;
        endcase
      end
    end
  end

  p_quiet_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == E_IDLE) |-> !sda_low_o);
  p_code_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |-> (code_o == ST_ADDR_ACK || code_o == ST_TX_ACK ||
              code_o == ST_TX_NACK || code_o == ST_LAST_ACK));
endmodule

// File: rtl/i2c_slv_tx.sv
module i2c_slv_tx
  import i2c_st_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR   = 7'h2A,
  parameter int         PRESC_DIV  = 50000,
  parameter int         TO_TICKS   = 25,
  parameter int         START_HOLD = 16,
  parameter int         SYNC_STG   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  logic [1:0] lvl, rise, fall;
  logic       scl_s, sda_s, start_det, stop_det;

  i2c_st_sync #(.N(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .in_i({scl_i, sda_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );
  assign scl_s     = lvl[1];
  assign sda_s     = lvl[0];
  assign start_det = fall[0] & scl_s;
  assign stop_det  = rise[0] & scl_s;

  logic       si, aa;
  logic [7:0] status, data;
  logic       wr_ctrl, clr, aa_eff;
  logic       load, rel, req, cancel;
  logic       from_ab, from_cx, from_tmo;

  assign wr_ctrl  = reg_we_i && reg_addr_i == REG_CTRL;
  assign clr      = wr_ctrl && si && !reg_wdata_i[CB_SI];
  assign aa_eff   = wr_ctrl ? reg_wdata_i[CB_AA] : aa;
  assign from_ab  = status == ST_ADDR_ACK || status == ST_TX_ACK;
  assign from_cx  = status == ST_TX_NACK || status == ST_LAST_ACK;
  assign from_tmo = status == ST_SCL_TMO;
  assign load     = clr && from_ab && !reg_wdata_i[CB_STO];
  assign rel      = clr && (from_cx || from_tmo || reg_wdata_i[CB_STO]);
  assign req      = clr && from_cx && reg_wdata_i[CB_STA];
  assign cancel   = clr && from_tmo;

  logic       eng_ev, eng_low, tmo_ev, pend, gen_drive;
  logic [7:0] eng_code;

  i2c_st_engine #(.OWN_ADDR(OWN_ADDR)) u_eng (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(rise[1]), .scl_fall_i(fall[1]),
    .start_i(start_det), .stop_i(stop_det),
    .aa_i(aa_eff), .data_i(data), .load_i(load), .release_i(rel),
    .ev_o(eng_ev), .code_o(eng_code), .sda_low_o(eng_low)
  );

  i2c_st_timeout #(.PRESC_DIV(PRESC_DIV), .TO_TICKS(TO_TICKS)) u_tmo (
    .clk_i, .rst_ni, .scl_i(scl_s), .to_o(tmo_ev)
  );

  i2c_st_startgen #(.START_HOLD(START_HOLD)) u_sgen (
    .clk_i, .rst_ni, .req_i(req), .cancel_i(cancel),
    .start_i(start_det), .stop_i(stop_det),
    .scl_i(scl_s), .sda_i(sda_s),
    .pend_o(pend), .drive_o(gen_drive)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      si     <= 1'b0;
      aa     <= 1'b0;
      status <= ST_NONE;
      data   <= '0;
    end else begin
      if (wr_ctrl) aa <= reg_wdata_i[CB_AA];
      if (reg_we_i && reg_addr_i == REG_DATA) data <= reg_wdata_i;
      if (tmo_ev) begin
        si     <= 1'b1;
        status <= ST_SCL_TMO;
      end else if (eng_ev) begin
        si     <= 1'b1;
        status <= eng_code;
      end else if (clr) begin
        si     <= 1'b0;
        status <= ST_NONE;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o = {4'b0, pend, 1'b0, si, aa};
      REG_STAT: reg_rdata_o = status;
      REG_DATA: reg_rdata_o = data;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o    = si;
  assign sda_oe_o = eng_low | gen_drive;

  p_idle_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !si |-> status == ST_NONE);
  p_ev_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_ev || tmo_ev) |=> si);
endmodule

// File: tb/tb_i2c_slv_tx.sv
module tb_i2c_slv_tx;
  localparam logic [6:0] OWN = 7'h2A;
  localparam int T = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, sda_oe;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_line;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_slv_tx #(.OWN_ADDR(OWN), .PRESC_DIV(4), .TO_TICKS(40), .START_HOLD(16)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string      tag_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    tag_q.push_back(tag);
    exp_q.push_back(exp);
    got_q.push_back(got);
  endtask

  always @(negedge clk) begin
    if (got_q.size() > 0) begin
      string t;
      logic [7:0] e, g;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      g = got_q.pop_front();
      n_chk++;
      if (g !== e) begin
        n_err++;
        $display("FAIL %s: actual %h expected %h", t, g, e);
      end
    end
  end

  task automatic wc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic bstart();
    scl_m = 1'b1; sda_m = 1'b1; wc(T);
    sda_m = 1'b0; wc(T);
    scl_m = 1'b0; wc(T);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wc(T);
    scl_m = 1'b1; wc(T);
    sda_m = 1'b1; wc(T);
  endtask

  task automatic bbit(logic b, output logic s);
    sda_m = b; wc(T);
    scl_m = 1'b1; wc(T);
    s = sda_line;
    scl_m = 1'b0; wc(T);
  endtask

  task automatic baddr(logic [6:0] a, output logic ack);
    logic s;
    bstart();
    for (int i = 6; i >= 0; i--) bbit(a[i], s);
    bbit(1'b1, s);
    bbit(1'b1, ack);
  endtask

  task automatic bread(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bbit(1'b1, b[i]);
  endtask

  task automatic wirq();
    for (int i = 0; i < 60 && !irq; i++) @(negedge clk);
  endtask

  task automatic chk_stat(string tag, logic [7:0] exp);
    logic [7:0] v;
    wirq();
    chk({tag, " irq"}, {7'b0, irq}, 8'h01);
    rd(2'd1, v);
    chk({tag, " status"}, v, exp);
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic ack, s;
    wc(3);
    rst_ni = 1'b1;
    wc(2);
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 oe", {7'b0, sda_oe}, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'hF8);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);

    // R2 AA=0 ignores own address
    baddr(OWN, ack);
    chk("R2 ack slot", {7'b0, ack}, 8'h01);
    wc(5); chk("R2 irq", {7'b0, irq}, 8'h00);
    bstop();

    // R3 other address ignored
    wr(2'd0, 8'h01);
    baddr(7'h15, ack);
    chk("R3 ack slot", {7'b0, ack}, 8'h01);
    wc(5); chk("R3 irq", {7'b0, irq}, 8'h00);
    bstop();

    // R4..R7
    baddr(OWN, ack);
    chk("R4 ack slot", {7'b0, ack}, 8'h00);
    chk_stat("R4", 8'hA8);
    wr(2'd2, 8'hA5);
    wr(2'd0, 8'h01);
    wc(1);
    chk("R5 irq", {7'b0, irq}, 8'h00);
    rd(2'd1, v); chk("R5 status", v, 8'hF8);
    bread(v); chk("R6 byte", v, 8'hA5);
    bbit(1'b0, s);
    chk_stat("R7", 8'hB8);

    // R8 last byte with AA=0
    wr(2'd2, 8'h3C);
    wr(2'd0, 8'h00);
    bread(v); chk("R6 byte2", v, 8'h3C);
    bbit(1'b0, s);
    chk_stat("R8", 8'hC8);
    wr(2'd0, 8'h01);
    bstop();

    // R10 recognition kept, R9 nack
    baddr(OWN, ack);
    chk("R10 ack with AA=1", {7'b0, ack}, 8'h00);
    chk_stat("R10", 8'hA8);
    wr(2'd2, 8'h81);
    wr(2'd0, 8'h01);
    bread(v); chk("R6 byte3", v, 8'h81);
    bbit(1'b1, s);
    chk_stat("R9", 8'hC0);
    wr(2'd0, 8'h00);
    bstop();
    baddr(OWN, ack);
    chk("R10 ack with AA=0", {7'b0, ack}, 8'h01);
    wc(5); chk("R10 irq", {7'b0, irq}, 8'h00);
    bstop();

    // R11 deferred START
    wr(2'd0, 8'h01);
    baddr(OWN, ack);
    chk_stat("R11 setup", 8'hA8);
    wr(2'd2, 8'h55);
    wr(2'd0, 8'h01);
    bread(v);
    bbit(1'b1, s);
    chk_stat("R11 nack", 8'hC0);
    wr(2'd0, 8'h09);
    rd(2'd0, v); chk("R11 pending", v, 8'h09);
    wc(40);
    chk("R11 quiet while busy", {7'b0, sda_oe}, 8'h00);
    sda_m = 1'b0; wc(T);
    scl_m = 1'b1; wc(T);
    sda_m = 1'b1; wc(10);
    chk("R11 start driven", {7'b0, sda_oe}, 8'h01);
    chk("R11 scl high", {7'b0, scl_m}, 8'h01);
    rd(2'd0, v); chk("R11 pend cleared", v, 8'h01);
    wc(30);
    chk("R11 released", {7'b0, sda_oe}, 8'h00);
    wc(10);

    // R12 timeout
    scl_m = 1'b0; wc(100);
    chk("R12 early", {7'b0, irq}, 8'h00);
    scl_m = 1'b1; wc(10);
    scl_m = 1'b0; wc(140);
    chk("R12 restarted", {7'b0, irq}, 8'h00);
    wc(40);
    chk_stat("R12", 8'hD8);
    wr(2'd0, 8'h01);
    wc(1);
    chk("R13 irq", {7'b0, irq}, 8'h00);
    rd(2'd1, v); chk("R13 status", v, 8'hF8);
    wc(200);
    chk("R12 single fire", {7'b0, irq}, 8'h00);
    scl_m = 1'b1; wc(10);
    baddr(OWN, ack);
    chk("R13 ack after reset", {7'b0, ack}, 8'h00);
    chk_stat("R13", 8'hA8);
    wr(2'd0, 8'h05);
    bstop();

    wait (got_q.size() == 0);
    wc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule